// File: doc/BRIEF.md
# Token-passing parallel link master

This block is the host end of an 8-bit parallel link to a network coprocessor. The link has three control lines: an active-low chip select, a read/write select and an address select. The right to write, called the token, passes back and forth between the host and the peer without end. When the controller holds the token, it writes a length byte and then that many payload bytes. A length of zero hands the token over with no payload. The controller then reads the peer's length byte and the peer's payload, and after that it holds the token again.

The peer reports a busy/ready handshake bit. The address select line places that bit on data line 0. Before each data byte, in either direction, the controller runs status reads and repeats them until the peer reports ready. The control outputs have a fixed skew: the read/write line trails the internal chip-select timing by one clock, and the address select trails it by two. Each access therefore begins with a setup window in which chip select stays high until both lines have settled.

On the host side the block offers a transmit stream (a pending-frame flag with a length, then payload bytes taken one at a time) and a receive stream (payload bytes with a last-byte marker, or a pulse for an empty token). It also takes the peer's interrupt line, which gates the payload of a non-empty outgoing frame.

Top module: `tpl_master`

## Requirements
- R1: During reset and after it, cs_n, rw_n and a0 are high, d_oe is low and no stream pulse is raised. The first data byte after reset is a host write, because the host holds the token first.
- R2: Every access with a0 low is preceded by a status read (a0 high). Bit 0 of that read must be 0 (ready), and no other access may lie between the two. A status read that returns bit 0 = 1 (busy) is followed by another status read.
- R3: cs_n goes low for exactly STRB_CYC consecutive cycles for each single-byte access. a0 and rw_n do not change while cs_n is low.
- R4: Once cs_n rises, rw_n keeps its value for at least one more cycle and a0 for at least two more cycles.
- R5: d_oe is high exactly when cs_n and rw_n are both low (a data write with a0 low). While d_oe is high, d_out holds the byte being written.
- R6: While the token is held, the length byte written is tx_len if tx_pend is 1. If tx_pend is 0, the length byte is 0 and tx_len is ignored. tx_len_ack pulses once when a pending length is taken. Payload bytes come from tx_data, one per tx_ack pulse, in order. A byte is taken only while tx_valid is 1.
- R7: After a non-zero length byte is written, cs_n stays high until irq has been seen high. After a zero length byte, irq is not awaited.
- R8: After its own frame or empty token, the controller reads the peer's length byte. A zero length gives one rx_null pulse. A non-zero length delivers that many bytes on rx_data with rx_valid, and raises rx_last on the final byte. The controller then holds the token again.
- R9: Frames of the maximum length, 255 bytes, are sent and received complete in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_pend | input | 1 | Host has a frame to send at the next token |
| tx_len | input | 8 | Payload length of the pending frame |
| tx_len_ack | output | 1 | One-cycle pulse: pending length taken |
| tx_valid | input | 1 | tx_data holds the next payload byte |
| tx_data | input | 8 | Transmit payload byte |
| tx_ack | output | 1 | One-cycle pulse: payload byte taken |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a received byte |
| rx_data | output | 8 | Received payload byte |
| rx_last | output | 1 | Qualifies rx_valid: final byte of the frame |
| rx_null | output | 1 | One-cycle pulse: peer passed an empty token |
| irq | input | 1 | Peer interrupt: ready for outgoing payload |
| cs_n | output | 1 | Link chip select, active low |
| rw_n | output | 1 | Link direction: 0 write, 1 read |
| a0 | output | 1 | Address select: 1 status, 0 data |
| d_out | output | 8 | Link data driven by the host |
| d_oe | output | 1 | Enable for the d_out driver |
| d_in | input | 8 | Link data from the peer; bit 0 is the handshake when a0 is 1 |

## Verification
The bench sweeps every pair of transmit and receive lengths from 0 to 5, and adds a 255-byte round in each direction. Across these rounds it varies how long the peer stays busy, how late its interrupt arrives, and whether the transmit stream stalls. A design that skipped or misread the handshake would strobe a data byte that no ready status preceded. A design that waited for irq after an empty token would hang. An 8-bit counter that wrapped or ended one byte early would lose bytes or move rx_last in the 255-byte round. Other rounds check that tx_len is ignored when no frame is pending, and look for a0 or rw_n changing inside a strobe or too soon after one.

// File: rtl/tpl_master.sv
module tpl_master #(
  parameter int SETUP_CYC = 3,
  parameter int STRB_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_pend,
  input  logic [7:0] tx_len,
  output logic       tx_len_ack,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ack,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_last,
  output logic       rx_null,
  input  logic       irq,
  output logic       cs_n,
  output logic       rw_n,
  output logic       a0,
  output logic [7:0] d_out,
  output logic       d_oe,
  input  logic [7:0] d_in
);
  localparam int TMAX = (SETUP_CYC > STRB_CYC) ? SETUP_CYC : STRB_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_LEN, S_SETUP, S_STRB, S_IRQ, S_TXW} st_t;
  typedef enum logic [1:0] {P_TXL, P_TXP, P_RXL, P_RXP} ph_t;

  st_t         st;
  ph_t         ph;
  logic        stat_op;
  logic [TW-1:0] tmr;
  logic [7:0]  rem, d_q;
  logic [1:0]  a0_d;
  logic        rw_d;
  logic        rw_i;

  assign rw_i  = stat_op | ph[1];
  assign cs_n  = (st != S_STRB);
  assign rw_n  = rw_d;
  assign a0    = a0_d[1];
  assign d_out = d_q;
  assign d_oe  = ~cs_n & ~rw_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_LEN;  ph <= P_TXL;  stat_op <= 1'b1;
      tmr <= '0;    rem <= '0;    d_q <= '0;
      a0_d <= 2'b11; rw_d <= 1'b1;
      tx_len_ack <= 1'b0; tx_ack <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; rx_last <= 1'b0; rx_null <= 1'b0;
    end else begin
      tx_len_ack <= 1'b0; tx_ack <= 1'b0;
      rx_valid <= 1'b0; rx_last <= 1'b0; rx_null <= 1'b0;
      a0_d <= {a0_d[0], stat_op};
      rw_d <= rw_i;
      case (st)
        S_LEN: begin
          d_q        <= tx_pend ? tx_len : 8'd0;
          tx_len_ack <= tx_pend;
          stat_op    <= 1'b1;
          tmr        <= '0;
          st         <= S_SETUP;
        end
        S_IRQ: if (irq) st <= S_TXW;
        S_TXW: if (tx_valid) begin
          d_q     <= tx_data;
          tx_ack  <= 1'b1;
          stat_op <= 1'b1;
          tmr     <= '0;
          st      <= S_SETUP;
        end
        S_SETUP: begin
          if (tmr == TW'(SETUP_CYC - 1)) begin
            tmr <= '0;
            st  <= S_STRB;
          end else tmr <= tmr + 1'b1;
        end
        S_STRB: begin
          if (tmr != TW'(STRB_CYC - 1)) tmr <= tmr + 1'b1;
          else begin
            tmr <= '0;
            st  <= S_SETUP;
            if (stat_op) begin
              if (!d_in[0]) stat_op <= 1'b0;
            end else begin
              stat_op <= 1'b1;
              case (ph)
                P_TXL: begin
                  if (d_q == 8'd0) ph <= P_RXL;
                  else begin
                    rem <= d_q;
                    ph  <= P_TXP;
                    st  <= S_IRQ;
                  end
                end
                P_TXP: begin
                  rem <= rem - 8'd1;
                  if (rem == 8'd1) ph <= P_RXL;
                  else st <= S_TXW;
                end
                P_RXL: begin
                  if (d_in == 8'd0) begin
                    rx_null <= 1'b1;
                    ph      <= P_TXL;
                    st      <= S_LEN;
                  end else begin
                    rem <= d_in;
                    ph  <= P_RXP;
                  end
                end
                P_RXP: begin
                  rx_valid <= 1'b1;
                  rx_data  <= d_in;
                  rx_last  <= (rem == 8'd1);
                  rem      <= rem - 8'd1;
                  if (rem == 8'd1) begin
                    ph <= P_TXL;
                    st <= S_LEN;
                  end
                end
                default: ph <= P_TXL;
              endcase
            end
          end
        end
        default: st <= S_LEN;
      endcase
    end
  end
endmodule

// File: rtl/tpl_master_chk.sv
module tpl_master_chk #(
  parameter int STRB_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rw_n,
  input logic       a0,
  input logic       d_oe,
  input logic [7:0] d_in,
  input logic       rx_valid,
  input logic       rx_null,
  input logic       tx_ack,
  input logic       tx_len_ack
);
  logic cs_q, cs_q2, hs_last, stat_ok;
  int   low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; cs_q2 <= 1'b1; hs_last <= 1'b1; stat_ok <= 1'b0; low_cnt <= 0;
    end else begin
      cs_q  <= cs_n;
      cs_q2 <= cs_q;
      if (!cs_n && a0) hs_last <= d_in[0];
      if (!cs_n) low_cnt <= low_cnt + 1;
      else low_cnt <= 0;
      if (cs_n && !cs_q) stat_ok <= a0 ? ~hs_last : 1'b0;
    end
  end

  AST_STRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cs_q) |-> ($stable(a0) && $stable(rw_n)));                 // R3
  AST_STRB_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_q) |-> (low_cnt == STRB_CYC));                          // R3
  AST_SKEW_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_q) |-> ($stable(a0) && $stable(rw_n)));                 // R4
  AST_SKEW_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_q && !cs_q2) |-> $stable(a0));                           // R4
  AST_BUS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (!cs_n && !rw_n && !a0));                                   // R5
  AST_HS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_q && !a0) |-> stat_ok);                                 // R2
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_null, tx_ack, tx_len_ack}));                  // R8
endmodule

bind tpl_master tpl_master_chk #(.STRB_CYC(STRB_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw_n(rw_n), .a0(a0), .d_oe(d_oe),
  .d_in(d_in), .rx_valid(rx_valid), .rx_null(rx_null), .tx_ack(tx_ack),
  .tx_len_ack(tx_len_ack)
);

// File: tb/tpl_master_bench.sv
module tpl_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STRB = 2;
  localparam int NR = 38;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_pend = 1'b0, tx_valid = 1'b1, irq_r = 1'b0;
  logic [7:0] tx_len = '0, tx_data = '0;
  logic tx_len_ack, tx_ack, rx_valid, rx_last, rx_null, cs_n, rw_n, a0, d_oe;
  logic [7:0] rx_data, d_out, d_in;

  logic hs_busy = 1'b0;
  logic [7:0] pbyte = '0, wbyte = '0;
  int nchk = 0, nerr = 0;
  int hr = 0, tidx = 0, ridx = 0, stall = 0;
  int pr = 0, pptr = 0, hcnt = 0, hlen = 0, busy_cnt = 0, irq_cnt = 0, low_cnt = 0;
  logic expect_len = 1'b1, await_irq = 1'b0, stat_ok = 1'b0, first_xfer = 1'b1;
  logic cs_prev = 1'b1, skew_pend = 1'b0, a0_rise = 1'b1;

  assign d_in = a0 ? {7'b0, hs_busy} : pbyte;

  tpl_master #(.SETUP_CYC(3), .STRB_CYC(STRB)) u_tpl_master (
    .clk(clk), .rst_n(rst_n), .tx_pend(tx_pend), .tx_len(tx_len), .tx_len_ack(tx_len_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ack(tx_ack), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_null(rx_null), .irq(irq_r), .cs_n(cs_n),
    .rw_n(rw_n), .a0(a0), .d_out(d_out), .d_oe(d_oe), .d_in(d_in)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int txl(int r);
    return (r < 36) ? r % 6 : (r == 36) ? 255 : 0;
  endfunction
  function automatic int txin(int r);
    return (r == 37) ? 7 : txl(r);
  endfunction
  function automatic logic pend(int r);
    return r != 37;
  endfunction
  function automatic int rxl(int r);
    return (r < 36) ? (r / 6) % 6 : (r == 36) ? 255 : 1;
  endfunction
  function automatic logic [7:0] txb(int r, int k);
    return 8'(r * 37 + k * 5 + 1);
  endfunction
  function automatic logic [7:0] rxb(int r, int k);
    return 8'(r * 11 + k * 3 + 7);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s round=%0d actual=%0d expected=%0d", tag, hr, act, exp);
    end
  endtask

  task automatic peer_step();
    logic rise, fall;
    rise = cs_n && !cs_prev;
    fall = !cs_n && cs_prev;
    if (skew_pend) begin
      chk(a0 == a0_rise, "R4", a0, a0_rise);
      skew_pend = 1'b0;
    end
    if (!cs_n && !rw_n && !a0) wbyte = d_out;
    if (!cs_n) chk(d_oe == !rw_n, "R5", d_oe, !rw_n);
    else if (d_oe) chk(1'b0, "R5", d_oe, 0);
    if (fall && await_irq) begin
      chk(irq_r, "R7", irq_r, 1);
      await_irq = 1'b0;
    end
    if (fall) irq_r = 1'b0;
    if (!cs_n) low_cnt++;
    if (rise) begin
      chk(low_cnt == STRB, "R3", low_cnt, STRB);
      low_cnt = 0;
      a0_rise = a0;
      skew_pend = 1'b1;
      if (a0) stat_ok = !hs_busy;
      else begin
        chk(stat_ok, "R2", stat_ok, 1);
        stat_ok = 1'b0;
        if (first_xfer) chk(!rw_n, "R1", rw_n, 0);
        first_xfer = 1'b0;
        busy_cnt = (pr % 3) * 4;
        if (!rw_n) begin
          if (expect_len) begin
            chk(wbyte == 8'(pend(pr) ? txin(pr) : 0), "R6", wbyte, pend(pr) ? txin(pr) : 0);
            if (wbyte != 0) begin
              hlen = wbyte; hcnt = 0; expect_len = 1'b0;
              irq_cnt = (pr % 4) + 1; await_irq = 1'b1;
            end
          end else begin
            if (pr == 36) chk(wbyte == txb(pr, hcnt), "R9", wbyte, txb(pr, hcnt));
            else chk(wbyte == txb(pr, hcnt), "R6", wbyte, txb(pr, hcnt));
            hcnt++;
            if (hcnt == hlen) expect_len = 1'b1;
          end
        end else begin
          pptr++;
          if (pptr == rxl(pr) + 1) begin
            pr++; pptr = 0; expect_len = 1'b1;
          end
        end
      end
    end
    if (irq_cnt > 0) begin
      irq_cnt--;
      if (irq_cnt == 0) irq_r = 1'b1;
    end
    hs_busy = (busy_cnt != 0) || (irq_cnt != 0);
    if (busy_cnt > 0) busy_cnt--;
    pbyte = (pptr == 0) ? 8'(rxl(pr)) : rxb(pr, pptr - 1);
    cs_prev = cs_n;
  endtask

  task automatic next_round();
    chk(tidx == txl(hr), "R6", tidx, txl(hr));
    hr++; tidx = 0; ridx = 0; stall = 0;
    tx_pend = pend(hr); tx_len = 8'(txin(hr)); tx_data = txb(hr, 0); tx_valid = 1'b1;
  endtask

  task automatic host_step();
    if (tx_len_ack) chk(pend(hr), "R6", tx_len_ack, pend(hr));
    if (tx_ack) begin
      tidx++;
      tx_data = txb(hr, tidx);
      stall = (hr % 2 == 1) ? 12 : 0;
    end
    if (stall > 0) begin tx_valid = 1'b0; stall--; end
    else tx_valid = 1'b1;
    if (rx_valid) begin
      if (hr == 36) chk(rx_data == rxb(hr, ridx), "R9", rx_data, rxb(hr, ridx));
      else chk(rx_data == rxb(hr, ridx), "R8", rx_data, rxb(hr, ridx));
      chk(rx_last == (ridx == rxl(hr) - 1), "R8", rx_last, ridx == rxl(hr) - 1);
      if (rx_last) next_round();
      else ridx++;
    end
    if (rx_null) begin
      chk(rxl(hr) == 0, "R8", 0, rxl(hr));
      next_round();
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    tx_pend = pend(0); tx_len = 8'(txin(0)); tx_data = txb(0, 0);
    pbyte = 8'(rxl(0));
    repeat (3) @(negedge clk);
    chk(cs_n && rw_n && a0 && !d_oe, "R1", {cs_n, rw_n, a0, d_oe}, 4'b1110);
    chk(!rx_valid && !rx_null && !tx_ack && !tx_len_ack, "R1",
        {rx_valid, rx_null, tx_ack, tx_len_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && rw_n && a0 && !d_oe, "R1", {cs_n, rw_n, a0, d_oe}, 4'b1110);
    while (hr < NR && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      peer_step();
      host_step();
    end
    if (hr < NR) begin
      nchk++; nerr++;
      $display("FAIL watchdog round=%0d actual=%0d expected=%0d", hr, hr, NR);
    end
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule